// File: doc/BRIEF.md
# Maskable Status Interrupt Aggregator

This block gathers a vector of raw condition signals from elsewhere in the chip, brings each through a synchronizer, and turns it into one bit of a status register. Every source has its own sensitivity setting. In level mode the status bit mirrors the synchronized condition. In rising-edge or falling-edge mode the bit records the edge and holds it until the host reads the status register. A per-source mask decides whether a set status bit may drive the shared, active-high interrupt line.

The host uses a plain parallel register port with a write strobe, a read strobe, an address and data. Through it the host sets the masks and sensitivities, and it reads status, which clears the latched edge bits it returns. Read data is registered and holds its value between reads. After reset every source is masked and in level mode, so the interrupt stays quiet until software enables it.

Top module: `stat_irq_agg`

## Requirements
- R1: After reset the mask register reads all ones, both sensitivity registers read zero, status reads zero, `rdata` is zero and `irq` is low.
- R2: The sensitivity code of source i is {bit i at 0x9, bit i at 0x8}. Codes 00 and 11 select level mode, in which status bit i equals the condition as it was SYNC_STAGES+1 clock edges earlier.
- R3: Code 01 (rising edge) sets status bit i when the synchronized condition goes from 0 to 1. The bit stays set, whatever the condition does, until a status read clears it.
- R4: Code 10 (falling edge) sets status bit i when the synchronized condition goes from 1 to 0. It holds the same way as in R3.
- R5: A read strobe at address 0xD loads the current status into `rdata` on the next edge. The same edge clears every edge-mode status bit. Level-mode bits are unaffected.
- R6: If a detected edge falls on the same clock edge as a status read-clear, the bit is set after that edge.
- R7: `irq` is the OR over all sources of (status AND NOT mask), registered once, so it follows status by one cycle. Sources whose mask bit is 1 never raise it.
- R8: The mask is written and read at 0xE, the low sensitivity bits at 0x8 and the high sensitivity bits at 0x9. A write to any other address changes nothing, and a read of any other address returns zero.
- R9: Reads of the mask or sensitivity registers leave status, including latched edge bits, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | NUM_SRC | Raw, asynchronous condition inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Registered read data, held between reads |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with NUM_SRC=6 and SYNC_STAGES=3. Six sources are enough to place level mode, the alternate level code, rising-edge mode and falling-edge mode side by side, with two sources left over for random traffic. The three-stage synchronizer stretches the path from input to status, so the bench can drive an edge that arrives in exactly the cycle of a read-clear. A non-default depth also checks that the latency follows the parameter.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_SENS_LO = 4'h8;
    localparam logic [ADDR_W-1:0] ADR_SENS_HI = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 4'hD;
    localparam logic [ADDR_W-1:0] ADR_MASK    = 4'hE;

    typedef enum logic [1:0] {
        SENS_LEVEL     = 2'b00,
        SENS_RISE      = 2'b01,
        SENS_FALL      = 2'b10,
        SENS_LEVEL_ALT = 2'b11
    } sens_e;

    function automatic logic is_level(input logic [1:0] code);
        return (code == SENS_LEVEL) || (code == SENS_LEVEL_ALT);
    endfunction

endpackage

// File: rtl/stat_irq_sync.sv
module stat_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dout = s_q.stg[STAGES-1];

endmodule

// File: rtl/stat_irq_cell.sv
module stat_irq_cell
    import stat_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cond,
    input  logic [1:0] mode,
    input  logic       clr,
    output logic       stat
);

    typedef struct packed {
        logic prev;
        logic stat;
    } cell_t;

    cell_t c_d, c_q;
    logic  rise_seen, fall_seen;

    always_comb begin
        c_d       = c_q;
        rise_seen = cond & ~c_q.prev;
        fall_seen = ~cond & c_q.prev;
        c_d.prev  = cond;
        case (mode)
            SENS_RISE: c_d.stat = rise_seen | (c_q.stat & ~clr);
            SENS_FALL: c_d.stat = fall_seen | (c_q.stat & ~clr);
            default:   c_d.stat = cond;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign stat = c_q.stat;

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!is_level(mode) && c_q.stat && !clr) |=> c_q.stat); // R3

    AST_LEVEL_NOT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (is_level(mode) && clr && cond) |=> c_q.stat); // R5

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mode == SENS_RISE && clr && cond && !c_q.prev) |=> c_q.stat); // R6

endmodule

// File: rtl/stat_irq_regs.sv
module stat_irq_regs
    import stat_irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] rdata,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] sens_lo,
    output logic [NUM_SRC-1:0] sens_hi,
    output logic               clr_stat
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] sens_lo;
        logic [NUM_SRC-1:0] sens_hi;
        logic [NUM_SRC-1:0] rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{mask: '1, sens_lo: '0, sens_hi: '0, rdata: '0};

    regs_t r_d, r_q;
    logic  hit_map;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                ADR_MASK:    r_d.mask    = wdata;
                ADR_SENS_LO: r_d.sens_lo = wdata;
                ADR_SENS_HI: r_d.sens_hi = wdata;
                default:     ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                ADR_STATUS:  r_d.rdata = status;
                ADR_MASK:    r_d.rdata = r_q.mask;
                ADR_SENS_LO: r_d.rdata = r_q.sens_lo;
                ADR_SENS_HI: r_d.rdata = r_q.sens_hi;
                default:     r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= REGS_RST;
        else     r_q <= r_d;
    end

    assign hit_map  = (addr == ADR_MASK) || (addr == ADR_SENS_LO) || (addr == ADR_SENS_HI);
    assign clr_stat = rd_en && (addr == ADR_STATUS);
    assign rdata    = r_q.rdata;
    assign mask     = r_q.mask;
    assign sens_lo  = r_q.sens_lo;
    assign sens_hi  = r_q.sens_hi;

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit_map) |=> ($stable(r_q.mask) && $stable(r_q.sens_lo) && $stable(r_q.sens_hi))); // R8

endmodule

// File: rtl/stat_irq_agg.sv
module stat_irq_agg
    import stat_irq_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cond_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq
);

    typedef struct packed {
        logic irq;
    } top_t;

    top_t               t_d, t_q;
    logic [NUM_SRC-1:0] cond_s;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] sens_lo;
    logic [NUM_SRC-1:0] sens_hi;
    logic               clr_stat;

    stat_irq_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cond_in),
        .dout (cond_s)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        stat_irq_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .cond (cond_s[g]),
            .mode ({sens_hi[g], sens_lo[g]}),
            .clr  (clr_stat),
            .stat (status[g])
        );
    end

    stat_irq_regs #(
        .NUM_SRC (NUM_SRC)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .status   (status),
        .rdata    (rdata),
        .mask     (mask),
        .sens_lo  (sens_lo),
        .sens_hi  (sens_hi),
        .clr_stat (clr_stat)
    );

    always_comb begin
        t_d     = t_q;
        t_d.irq = |(status & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign irq = t_q.irq;

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(&mask) |-> !irq); // R7

endmodule

// File: tb/stat_irq_agg_test.sv
module stat_irq_agg_test;

    localparam int NS = 6;
    localparam int ST = 3;
    localparam logic [3:0] AD_LO = 4'h8;
    localparam logic [3:0] AD_HI = 4'h9;
    localparam logic [3:0] AD_ST = 4'hD;
    localparam logic [3:0] AD_MK = 4'hE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] cond_in = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [NS-1:0] wdata = '0;
    logic [NS-1:0] rdata;
    logic          irq;

    always #4 clk = ~clk;

    stat_irq_agg #(.NUM_SRC(NS), .SYNC_STAGES(ST)) uut (
        .clk(clk), .rst(rst), .cond_in(cond_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string rd_tag = "R1";
    logic [NS-1:0] raw_v = '0;

    logic [NS-1:0] m_sync [ST];
    logic [NS-1:0] m_prev, m_stat, m_mask, m_lo, m_hi, m_rdata;
    logic          m_irq;

    function automatic logic [NS-1:0] reg_value(input logic [3:0] a);
        case (a)
            AD_ST:   return m_stat;
            AD_MK:   return m_mask;
            AD_LO:   return m_lo;
            AD_HI:   return m_hi;
            default: return '0;
        endcase
    endfunction

    function automatic logic [NS-1:0] next_status(input logic [NS-1:0] cs, input logic clr);
        logic [NS-1:0] ns;
        for (int i = 0; i < NS; i++) begin
            case ({m_hi[i], m_lo[i]})
                2'b01:   ns[i] = (cs[i] & ~m_prev[i]) | (m_stat[i] & ~clr);
                2'b10:   ns[i] = (~cs[i] & m_prev[i]) | (m_stat[i] & ~clr);
                default: ns[i] = cs[i];
            endcase
        end
        return ns;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < ST; k++) m_sync[k] = '0;
        m_prev = '0; m_stat = '0; m_mask = '1; m_lo = '0; m_hi = '0;
        m_rdata = '0; m_irq = 1'b0;
    endtask

    task automatic model_step(input logic [NS-1:0] raw, input logic we, input logic re,
                              input logic [3:0] a, input logic [NS-1:0] wd);
        logic [NS-1:0] cs, nstat, nrd;
        logic          nirq;
        cs    = m_sync[ST-1];
        nstat = next_status(cs, re && (a == AD_ST));
        nrd   = re ? reg_value(a) : m_rdata;
        nirq  = |(m_stat & ~m_mask);
        if (we) begin
            case (a)
                AD_MK:   m_mask = wd;
                AD_LO:   m_lo = wd;
                AD_HI:   m_hi = wd;
                default: ;
            endcase
        end
        m_prev = cs;
        for (int k = ST-1; k > 0; k--) m_sync[k] = m_sync[k-1];
        m_sync[0] = raw;
        m_stat  = nstat;
        m_rdata = nrd;
        m_irq   = nirq;
    endtask

    task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic we, input logic re, input logic [3:0] a,
                         input logic [NS-1:0] wd);
        cond_in = raw_v; wr_en = we; rd_en = re; addr = a; wdata = wd;
        if (re) rd_tag = (a == AD_ST) ? "R5" : "R8";
        model_step(raw_v, we, re, a, wd);
        @(negedge clk);
        chk("R7 irq", NS'(irq), NS'(m_irq));
        chk(rd_tag, rdata, m_rdata);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 4'h0, '0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [NS-1:0] d);
        cycle(1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [3:0] a);
        cycle(1'b0, 1'b1, a, '0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rdata", rdata, '0);
        chk("R1 irq", NS'(irq), '0);
        rd(AD_MK); chk("R1 mask", rdata, 6'h3F);
        rd(AD_LO); chk("R1 sens_lo", rdata, 6'h00);
        rd(AD_HI); chk("R1 sens_hi", rdata, 6'h00);
        rd(AD_ST); chk("R1 status", rdata, 6'h00);

        // src0 rise, src1 fall, src2 level 00, src3 level 11
        wr(AD_MK, 6'h00);
        wr(AD_LO, 6'b001001);
        wr(AD_HI, 6'b001010);
        rd(AD_LO); chk("R8 sens_lo", rdata, 6'b001001);
        raw_v = 6'b000010; idle(6);
        rd(AD_ST); chk("R3 none yet", rdata, 6'b000000);

        raw_v = 6'b000011; idle(6);
        chk("R7 irq unmasked", NS'(irq), 6'h01);
        rd(AD_ST); chk("R3 rise latched", rdata, 6'b000001);
        rd(AD_ST); chk("R5 edge cleared", rdata, 6'b000000);

        raw_v = 6'b001101; idle(6);
        rd(AD_ST); chk("R4 fall and R2 level", rdata, 6'b001110);
        rd(AD_ST); chk("R5 level kept", rdata, 6'b001100);

        wr(AD_MK, 6'h3F); idle(2);
        chk("R7 masked quiet", NS'(irq), 6'h00);

        raw_v = 6'b001100; idle(6);
        raw_v = 6'b001101; idle(6);
        rd(AD_MK); chk("R9 mask read", rdata, 6'h3F);
        rd(AD_HI);
        rd(AD_ST); chk("R9 status kept", rdata, 6'b001101);

        raw_v = 6'b001100; idle(6);
        rd(AD_ST); chk("R6 pre", rdata, 6'b001100);
        raw_v = 6'b001101; idle(ST);
        rd(AD_ST); chk("R6 same-cycle read", rdata, 6'b001100);
        rd(AD_ST); chk("R6 edge survives", rdata, 6'b001101);

        wr(4'h3, 6'h15);
        rd(AD_MK); chk("R8 unmapped mask", rdata, 6'h3F);
        rd(AD_LO); chk("R8 unmapped lo", rdata, 6'b001001);
        rd(4'h3);  chk("R8 unmapped read", rdata, 6'h00);

        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            int unsigned sel;
            logic [3:0]  a;
            if ($urandom_range(3) == 0) raw_v = NS'($urandom);
            sel = $urandom_range(4);
            case (sel)
                0: a = AD_LO;
                1: a = AD_HI;
                2: a = AD_ST;
                3: a = AD_MK;
                default: a = 4'($urandom);
            endcase
            case ($urandom_range(7))
                0:       cycle(1'b1, 1'b0, a, NS'($urandom));
                1, 2:    cycle(1'b0, 1'b1, a, '0);
                3:       cycle(1'b1, 1'b1, a, NS'($urandom));
                default: idle(1);
            endcase
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule